// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block supervises a battery-backed memory. It receives three comparator flags, one for each supply level: the full operating level, the write-protect level and the battery switchover level. Each flag is resynchronised and filtered. A five-state machine then decides whether the memory may be accessed and which source powers the memory array. While access is not granted, the block blocks writes, forces the data outputs to high impedance and makes the memory ignore its access inputs. When the supply falls below the switchover level, the block selects the battery. When power returns, the block holds protection for a fixed recovery window before it releases access.

The battery stays isolated until the supply reaches the operating level for the first time after reset. A drop of the supply during the recovery window sends the machine straight back to protection, and the window starts again from zero. All pins are plain level signals, because no data passes through the block. The recovery window is set in nanoseconds together with the clock frequency, and it is clamped to the range 2000 ns to 125000 ns.

Top module: `pfail_guard`

## Requirements
- R1: After reset, status is 5'b00001 (first-power state), all three protection outputs are 1 and battery select is 0.
- R2: Before the first entry into the recovery window, battery select stays 0 whatever the switchover flag does.
- R3: Each flag passes two synchronizer flops and must hold a new level for 4 consecutive cycles before it is used; a 3-cycle pulse on a flag has no effect on any output.
- R4: The recovery state lasts exactly REC_NS×CLK_MHZ/1000 cycles (200 by default). After that, the state becomes normal and all protection outputs drop to 0.
- R5: In the normal state, protection asserts in the same cycle that the filtered protect-level flag falls, and the state becomes protect on the next cycle.
- R6: In the normal state, a fall of the operating-level flag alone, with the protect-level flag still high, changes neither the state nor the protection outputs.
- R7: From the protect state, a fall of the switchover flag enters the backup state with battery select 1. When that flag rises again, the state returns to protect with battery select 0. Battery select is 1 in the backup state only.
- R8: From the protect state, the operating and protect flags both high start the recovery window. If the operating flag falls during the window, the state returns to protect at once, and a later recovery runs the full window again.
- R9: The write-block, output-disable and input-ignore outputs are equal at all times. They are 0 only in the normal state.
- R10: The status encoding is one-hot: bit0 first-power, bit1 normal, bit2 protect, bit3 backup, bit4 recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sup_run_i | input | 1 | Supply above the full operating level |
| sup_guard_i | input | 1 | Supply above the write-protect level |
| sup_switch_i | input | 1 | Supply above the battery switchover level |
| wr_block_o | output | 1 | Block all writes to the memory |
| out_hiz_o | output | 1 | Force the memory data outputs to high impedance |
| in_ignore_o | output | 1 | Make the memory ignore its access inputs |
| bat_sel_o | output | 1 | Power the memory array from the battery |
| status_o | output | 5 | One-hot current state |

## Verification
The supply flags are driven through a complete life cycle: first power-up, normal access, a slow decay through protection to battery backup, and recovery. A switchover-only rise before first power shows whether the battery isolation holds. A 3-cycle glitch on the protect flag and an isolated drop of the operating flag show whether the filter and the tolerance band reject disturbances that a real fault would not produce. The recovery window is measured twice, once clean and once after a brownout inside it. The second measurement tells a timer that restarts from a timer that resumes from where it stopped.

// File: rtl/pfail_pkg.sv
package pfail_pkg;
  typedef enum logic [4:0] {
    ST_FIRST = 5'b00001,
    ST_NORM  = 5'b00010,
    ST_PROT  = 5'b00100,
    ST_BACK  = 5'b01000,
    ST_RCV   = 5'b10000
  } pf_state_t;

  localparam int unsigned REC_NS_MIN = 2000;
  localparam int unsigned REC_NS_MAX = 125000;

  // flag positions in the filtered flag vector
  localparam int unsigned FL_RUN    = 0;
  localparam int unsigned FL_GUARD  = 1;
  localparam int unsigned FL_SWITCH = 2;
  localparam int unsigned FL_COUNT  = 3;

  function automatic int unsigned clamp_ns(input int unsigned ns);
    if (ns < REC_NS_MIN) return REC_NS_MIN;
    if (ns > REC_NS_MAX) return REC_NS_MAX;
    return ns;
  endfunction
endpackage

// File: rtl/pfail_flag_filter.sv
module pfail_flag_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_CYCLES  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic flt_o
);
  localparam int unsigned CW = $clog2(DEB_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   flt_q;
  logic                   sample;

  assign sample = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
    end
  end

  // level must differ from the accepted one for DEB_CYCLES edges in a row
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flt_q <= 1'b0;
    end else if (sample == flt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(DEB_CYCLES - 1)) begin
      flt_q <= sample;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign flt_o = flt_q;
endmodule

// File: rtl/pfail_rec_timer.sv
module pfail_rec_timer #(
  parameter int unsigned LIM = 200,
  parameter int unsigned CW  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  logic [CW-1:0] cnt_q;

  // cleared whenever the window is not open, so each entry restarts it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (cnt_q != CW'(LIM - 1)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = run_i && (cnt_q == CW'(LIM - 1));
endmodule

// File: rtl/pfail_fsm.sv
module pfail_fsm
  import pfail_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run_f_i,
  input  logic      guard_f_i,
  input  logic      switch_f_i,
  input  logic      rec_done_i,
  output pf_state_t state_o
);
  pf_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_FIRST: if (run_f_i && guard_f_i) st_d = ST_RCV;
      ST_NORM:  if (!guard_f_i) st_d = ST_PROT;
      ST_PROT: begin
        if (!switch_f_i)               st_d = ST_BACK;
        else if (run_f_i && guard_f_i) st_d = ST_RCV;
      end
      ST_BACK:  if (switch_f_i) st_d = ST_PROT;
      ST_RCV: begin
        if (!run_f_i || !guard_f_i) st_d = ST_PROT;
        else if (rec_done_i)        st_d = ST_NORM;
      end
      default: st_d = ST_FIRST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_FIRST;
    else        st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/pfail_guard.sv
module pfail_guard
  import pfail_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 100,
  parameter int unsigned REC_NS      = 2000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_CYCLES  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sup_run_i,
  input  logic       sup_guard_i,
  input  logic       sup_switch_i,
  output logic       wr_block_o,
  output logic       out_hiz_o,
  output logic       in_ignore_o,
  output logic       bat_sel_o,
  output logic [4:0] status_o
);
  localparam int unsigned REC_NS_C = clamp_ns(REC_NS);
  localparam int unsigned REC_RAW  = CLK_MHZ * REC_NS_C / 1000;
  localparam int unsigned REC_LIM  = (REC_RAW == 0) ? 1 : REC_RAW;
  localparam int unsigned REC_CW   = $clog2(REC_LIM + 1);

  logic [FL_COUNT-1:0] raw_flags;
  logic [FL_COUNT-1:0] flt_flags;
  logic                rec_done;
  logic                protect;
  pf_state_t           state;

  assign raw_flags[FL_RUN]    = sup_run_i;
  assign raw_flags[FL_GUARD]  = sup_guard_i;
  assign raw_flags[FL_SWITCH] = sup_switch_i;

  for (genvar g = 0; g < FL_COUNT; g++) begin : g_flag
    pfail_flag_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .DEB_CYCLES (DEB_CYCLES)
    ) i_filter (
      .clk  (clk),
      .rst_n(rst_n),
      .raw_i(raw_flags[g]),
      .flt_o(flt_flags[g])
    );
  end

  pfail_rec_timer #(
    .LIM(REC_LIM),
    .CW (REC_CW)
  ) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (state == ST_RCV),
    .done_o(rec_done)
  );

  pfail_fsm i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_f_i   (flt_flags[FL_RUN]),
    .guard_f_i (flt_flags[FL_GUARD]),
    .switch_f_i(flt_flags[FL_SWITCH]),
    .rec_done_i(rec_done),
    .state_o   (state)
  );

  // zero-delay protect: leaves no cycle of access once the guard flag drops
  assign protect     = !((state == ST_NORM) && flt_flags[FL_GUARD]);
  assign wr_block_o  = protect;
  assign out_hiz_o   = protect;
  assign in_ignore_o = protect;
  assign bat_sel_o   = (state == ST_BACK);
  assign status_o    = state;
endmodule

// File: rtl/pfail_guard_chk.sv
module pfail_guard_chk #(
  parameter int unsigned REC_LIM = 200,
  parameter int unsigned CW      = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_block,
  input logic       out_hiz,
  input logic       in_ignore,
  input logic       bat_sel,
  input logic [4:0] status
);
  localparam logic [4:0] S_FIRST = 5'b00001;
  localparam logic [4:0] S_NORM  = 5'b00010;
  localparam logic [4:0] S_PROT  = 5'b00100;
  localparam logic [4:0] S_RCV   = 5'b10000;

  logic [CW-1:0] rc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rc_q <= '0;
    else if (status == S_RCV) rc_q <= rc_q + 1'b1;
    else                     rc_q <= '0;
  end

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(status));

  p_first_nobat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (status == S_FIRST) |-> !bat_sel);

  p_bat_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bat_sel) |-> ($past(status) == S_PROT));

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_block |-> (status == S_NORM));

  p_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_block == out_hiz) && (out_hiz == in_ignore));

  p_fall_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((status == S_NORM) && wr_block) |=> (status == S_PROT));

  p_rec_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((status == S_NORM) && ($past(status) == S_RCV)) |-> (rc_q == CW'(REC_LIM)));

  p_rec_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status == S_RCV) |=> (status == S_RCV || status == S_NORM || status == S_PROT));
endmodule

bind pfail_guard pfail_guard_chk #(
  .REC_LIM(REC_LIM),
  .CW     (REC_CW)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_block (wr_block_o),
  .out_hiz  (out_hiz_o),
  .in_ignore(in_ignore_o),
  .bat_sel  (bat_sel_o),
  .status   (status_o)
);

// File: tb/test_pfail_guard.sv
module test_pfail_guard;
  localparam logic [4:0] S_FIRST = 5'b00001;
  localparam logic [4:0] S_NORM  = 5'b00010;
  localparam logic [4:0] S_PROT  = 5'b00100;
  localparam logic [4:0] S_BACK  = 5'b01000;
  localparam logic [4:0] S_RCV   = 5'b10000;
  localparam int REC_EXP = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, guard = 1'b0, sw = 1'b0;
  logic wr_block, out_hiz, in_ignore, bat_sel;
  logic [4:0] status;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {
    string      req;
    logic [4:0] st;
    logic       prot;
    logic       bat;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  pfail_guard i_pfail_guard (
    .clk(clk), .rst_n(rst_n),
    .sup_run_i(run), .sup_guard_i(guard), .sup_switch_i(sw),
    .wr_block_o(wr_block), .out_hiz_o(out_hiz), .in_ignore_o(in_ignore),
    .bat_sel_o(bat_sel), .status_o(status)
  );

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // driver side: queue what the ports must show at this negedge
  task automatic expect_now(input string req, input logic [4:0] st,
                            input logic prot, input logic bat);
    exp_t e;
    e.req = req; e.st = st; e.prot = prot; e.bat = bat;
    sb_q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops and compares shortly after each negedge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk({e.req, " status"}, status == e.st, int'(status), int'(e.st));
        chk({e.req, " protect"},
            (wr_block == e.prot) && (out_hiz == e.prot) && (in_ignore == e.prot),
            int'({wr_block, out_hiz, in_ignore}), e.prot ? 7 : 0);
        chk({e.req, " battery"}, bat_sel == e.bat, int'(bat_sel), int'(e.bat));
      end
    end
  end

  task automatic measure_rcv(input string req);
    int n = 0;
    int w = 0;
    @(negedge clk); #1;
    while (status != S_RCV && w < 100) begin
      @(negedge clk); #1;
      w++;
    end
    while (status == S_RCV && n < 20000) begin
      n++;
      @(negedge clk); #1;
    end
    chk(req, n == REC_EXP, n, REC_EXP);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    expect_now("R1", S_FIRST, 1'b1, 1'b0);
    expect_now("R10 first", S_FIRST, 1'b1, 1'b0);

    // R2: switchover level alone, then gone again, before first power
    sw = 1'b1; step(20);
    expect_now("R2 sw up", S_FIRST, 1'b1, 1'b0);
    sw = 1'b0; step(20);
    expect_now("R2 sw down", S_FIRST, 1'b1, 1'b0);

    // R4: first power-up and the recovery window
    sw = 1'b1; guard = 1'b1; run = 1'b1;
    measure_rcv("R4 window");
    step(1);
    expect_now("R4 released", S_NORM, 1'b0, 1'b0);

    // R3: 3-cycle glitch on the guard flag
    guard = 1'b0; step(3); guard = 1'b1; step(20);
    expect_now("R3 glitch", S_NORM, 1'b0, 1'b0);

    // R6: operating flag drops alone
    run = 1'b0; step(20);
    expect_now("R6 band", S_NORM, 1'b0, 1'b0);
    run = 1'b1; step(20);
    expect_now("R6 back", S_NORM, 1'b0, 1'b0);

    // R5: guard drop, zero-delay protect (2 sync + 4 filter edges)
    guard = 1'b0; run = 1'b0;
    step(6);
    expect_now("R5 same cycle", S_NORM, 1'b1, 1'b0);
    step(1);
    expect_now("R5 next", S_PROT, 1'b1, 1'b0);
    step(20);
    expect_now("R9 protect", S_PROT, 1'b1, 1'b0);

    // R7: into and out of battery backup
    sw = 1'b0; step(20);
    expect_now("R7 backup", S_BACK, 1'b1, 1'b1);
    sw = 1'b1; step(20);
    expect_now("R7 return", S_PROT, 1'b1, 1'b0);

    // R8: brownout inside the window, then a full window again
    guard = 1'b1; run = 1'b1; step(60);
    expect_now("R8 in window", S_RCV, 1'b1, 1'b0);
    run = 1'b0; step(20);
    expect_now("R8 abort", S_PROT, 1'b1, 1'b0);
    run = 1'b1;
    measure_rcv("R8 restart");
    step(1);
    expect_now("R8 released", S_NORM, 1'b0, 1'b0);

    step(3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule